// File: doc/BRIEF.md
# SPI Master Word Engine

This block is the serial core of an SPI master. It turns one parallel word at a time into a serial clock and a data stream, and it assembles the bits that come back into a received word. The format inputs are held steady while the engine is busy. They set the serial clock rate, the word length, the clock idle level, the sampling phase, the bit order, an optional parity bit and an idle gap after each word.

Software or a sequencer writes a word into a one-deep transmit holding register whenever `tx_full` is low. The shifter takes that word as soon as it is free. Words therefore follow one another with no idle clocks when the gap is zero. Received words land in a one-deep receive register. That register raises a parity error if the parity check fails and raises an overrun if a word was not read in time. A loopback switch feeds the outgoing data line straight into the receiver.

Top module: `spi_word_engine`

## Requirements
- R1: With `cfg_prescale` = P (2..255), every serial bit lasts D = P+1 clock cycles. SCLK is idle for the first floor(D/2) cycles of a bit and active for the rest.
- R2: With `cfg_charlen` = L (2..16), each word produces exactly L active SCLK pulses, or L+1 when parity is enabled.
- R3: With `cfg_lsb_first` = 1, data bit 0 is sent first and received into bit 0. With `cfg_lsb_first` = 0, bit L-1 goes first and the first received bit lands in bit L-1.
- R4: Whenever `busy` is low, SCLK equals `cfg_cpol`. During the gap it also rests at `cfg_cpol`.
- R5: With `cfg_phase` = 1, MOSI holds bit k for the whole of bit period k, and MOSI and MISO are sampled on the leading SCLK edge. With `cfg_phase` = 0, MOSI moves to bit k on the leading edge of period k, and both lines are sampled on the trailing edge.
- R6: With `cfg_par_en` = 1, one parity bit follows the data bits. Its value is the XOR of the L data bits, XORed with `cfg_par_odd`. A received parity bit that differs from this value sets `rx_par_err` together with that word.
- R7: After each word, SCLK stays idle for `cfg_gap` × D cycles and `busy` stays high. A single word keeps `busy` high for (L + parity + gap) × D cycles.
- R8: `tx_wr` while `tx_full` is low stores `tx_data` and raises `tx_full`. A write while `tx_full` is high is ignored. `tx_full` falls when the shifter takes the word. A word waiting at the end of the previous word or gap starts with no idle cycle.
- R9: A finished word sets `rx_data` and clears `rx_empty`. `rx_data` is right-justified with zeros above bit L-1. `rx_rd` sets `rx_empty`.
- R10: A word that arrives while `rx_empty` is low and `rx_rd` is not asserted sets `rx_overrun`. `rx_rd` clears it.
- R11: With `cfg_loopback` = 1, the receiver takes MOSI and ignores the `miso` pin.
- R12: After reset: `busy`, `tx_full`, `rx_overrun`, `rx_par_err` and `mosi` are 0, `rx_empty` is 1, and SCLK rests at `cfg_cpol`. MOSI is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_prescale | input | 8 | Serial clock divisor minus one (2..255) |
| cfg_charlen | input | 5 | Data bits per word (2..16) |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_phase | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | Odd parity when set |
| cfg_gap | input | 6 | Idle bit periods after each word |
| cfg_loopback | input | 1 | Receiver listens to MOSI |
| tx_data | input | 16 | Word to send |
| tx_wr | input | 1 | Transmit write strobe |
| tx_full | output | 1 | Holding register occupied |
| rx_data | output | 16 | Last received word, right-justified |
| rx_rd | input | 1 | Receive read strobe |
| rx_empty | output | 1 | No unread word |
| rx_overrun | output | 1 | An unread word was replaced |
| rx_par_err | output | 1 | Parity mismatch on the held word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word or gap in progress |

## Verification
The stimulus is mainly random. Each run picks a random word length, divisor, polarity, phase, bit order, parity mode, gap and loopback setting, and checks the result against bench models of the line order and parity. A behavioural slave drives MISO on the launch edge that matches the selected phase. Random MISO bits that mismatch the parity half of the time separate a correct parity check from a stuck flag. In loopback runs the slave drives the complement of MOSI, so a receiver that listens to the pin is caught.

Directed cases cover:
- the divisor and length extremes;
- a maximal gap;
- back-to-back words, which reveal idle cycles between words and the overrun;
- a write into a full holding register, which would otherwise add a word.

// File: rtl/spi_eng_pkg.sv
// Shared format field widths, engine state encoding and the format bundle
// used between the top and the shifter. Assumes format fields are static
// while the engine is busy.
package spi_eng_pkg;
    localparam int PRE_W = 8;   // prescale field width
    localparam int LEN_W = 5;   // character length field width
    localparam int GAP_W = 6;   // inter-word gap field width

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_XFER = 2'd1,
        ENG_GAP  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic [LEN_W-1:0] charlen;
        logic             cpol;
        logic             phase;
        logic             lsb_first;
        logic             par_en;
        logic             par_odd;
        logic [GAP_W-1:0] gap;
    } fmt_t;
endpackage

// File: rtl/spi_tx_hold.sv
// One-word transmit holding register. Accepts a write only while empty and
// is emptied when the shifter takes the word. Assumes take is only raised
// while full.
module spi_tx_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    // Capture a word when empty; release it when the shifter loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            full <= 1'b1;
            word <= wdata;
        end
    end

    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full); // R8
    AST_FULL_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(word))); // R8
endmodule

// File: rtl/spi_rx_hold.sv
// One-word receive register with empty, overrun and parity-error flags.
// A delivery in the same cycle as a read counts the read first.
module spi_rx_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] pdata,
    input  logic              pperr,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              empty,
    output logic              ovr,
    output logic              perr
);
    // Store delivered words and keep the flags that describe them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
            ovr   <= 1'b0;
            perr  <= 1'b0;
        end else if (put) begin
            data  <= pdata;
            empty <= 1'b0;
            ovr   <= !rd && (ovr || !empty);
            perr  <= pperr;
        end else if (rd) begin
            empty <= 1'b1;
            ovr   <= 1'b0;
            perr  <= 1'b0;
        end
    end

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(!empty && put)); // R10
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !put) |=> (empty && !ovr)); // R9
endmodule

// File: rtl/spi_serdes.sv
// Word shifter: bit timing from the prescaler, serial clock shaping, data
// launch and capture for both phases, parity generation and checking, and
// the inter-word gap. Assumes prescale >= 2 and charlen in 2..DATA_W.
module spi_serdes
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_t              fmt,
    input  logic              word_avail,
    input  logic [DATA_W-1:0] word_in,
    input  logic              rx_line,
    output logic              take,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              put,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_perr
);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam int SEL_W = $clog2(DATA_W);

    eng_state_e        st;
    logic [PRE_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx, oidx, len, nbits;
    logic [GAP_W-1:0]  gcnt;
    logic [DATA_W-1:0] sh, acc, acc_n, len_mask;
    logic              accp, accp_n;
    logic [PRE_W:0]    half, half_m1;
    logic              xfer, end_per, lead, smp, last_bit, gap_end, tx_par;

    // Derived timing and word-size terms from the static format.
    always_comb begin
        half     = ({1'b0, fmt.prescale} + {{PRE_W{1'b0}}, 1'b1}) >> 1;
        half_m1  = half - {{PRE_W{1'b0}}, 1'b1};
        len      = IDX_W'(fmt.charlen);
        nbits    = len + IDX_W'(fmt.par_en);
        for (int b = 0; b < DATA_W; b++) len_mask[b] = (b < int'(len));
    end

    assign xfer     = (st == ENG_XFER);
    assign end_per  = (cnt == fmt.prescale);
    assign lead     = xfer && ({1'b0, cnt} == half_m1);
    assign smp      = fmt.phase ? lead : (xfer && end_per);
    assign last_bit = (idx == nbits - IDX_W'(1));
    assign gap_end  = (st == ENG_GAP) && end_per && (gcnt == fmt.gap - GAP_W'(1));
    assign take     = word_avail && ((st == ENG_IDLE) || gap_end ||
                      (xfer && end_per && last_bit && fmt.gap == '0));
    assign busy     = (st != ENG_IDLE);
    assign sclk     = fmt.cpol ^ (xfer && ({1'b0, cnt} >= half));
    assign tx_par   = (^(sh & len_mask)) ^ fmt.par_odd;

    // Outgoing bit index: late phase keeps the previous bit until the leading edge.
    always_comb begin
        oidx = idx;
        if (!fmt.phase && idx != '0 && ({1'b0, cnt} < half)) oidx = idx - IDX_W'(1);
    end

    // Select the line bit for the outgoing index in the chosen bit order.
    always_comb begin
        mosi = 1'b0;
        if (xfer) begin
            if (oidx >= len)        mosi = tx_par;
            else if (fmt.lsb_first) mosi = sh[SEL_W'(oidx)];
            else                    mosi = sh[SEL_W'(len - IDX_W'(1) - oidx)];
        end
    end

    // Capture the incoming line bit into its right-justified position.
    always_comb begin
        acc_n  = acc;
        accp_n = accp;
        if (smp) begin
            if (idx >= len)         accp_n = rx_line;
            else if (fmt.lsb_first) acc_n[SEL_W'(idx)] = rx_line;
            else                    acc_n[SEL_W'(len - IDX_W'(1) - idx)] = rx_line;
        end
    end

    assign put     = xfer && end_per && last_bit;
    assign rx_word = acc_n;
    assign rx_perr = fmt.par_en && (accp_n != ((^acc_n) ^ fmt.par_odd));

    // Sequence words through transfer, gap and idle; loads override captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ENG_IDLE;
            cnt  <= '0;
            idx  <= '0;
            gcnt <= '0;
            sh   <= '0;
            acc  <= '0;
            accp <= 1'b0;
        end else begin
            acc  <= acc_n;
            accp <= accp_n;
            case (st)
                ENG_IDLE: ;
                ENG_XFER: begin
                    if (end_per) begin
                        cnt <= '0;
                        if (last_bit) begin
                            gcnt <= '0;
                            st   <= (fmt.gap != '0) ? ENG_GAP : ENG_IDLE;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + PRE_W'(1);
                    end
                end
                ENG_GAP: begin
                    if (end_per) begin
                        cnt <= '0;
                        if (gap_end) st <= ENG_IDLE;
                        else         gcnt <= gcnt + GAP_W'(1);
                    end else begin
                        cnt <= cnt + PRE_W'(1);
                    end
                end
                default: st <= ENG_IDLE;
            endcase
            if (take) begin
                st   <= ENG_XFER;
                cnt  <= '0;
                idx  <= '0;
                sh   <= word_in;
                acc  <= '0;
                accp <= 1'b0;
            end
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= fmt.prescale)); // R1
    AST_IDX_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (idx < nbits)); // R2
    AST_PUT_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        put |=> (st != ENG_XFER || idx == '0)); // R9
endmodule

// File: rtl/spi_word_engine.sv
// Top of the SPI master word engine: transmit holding register, shifter and
// receive register, with the loopback select on the receive line.
// Assumes the cfg_* inputs are static while busy is high.
module spi_word_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [LEN_W-1:0]  cfg_charlen,
    input  logic              cfg_cpol,
    input  logic              cfg_phase,
    input  logic              cfg_lsb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_loopback,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_rd,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              rx_par_err,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);
    fmt_t              fmt;
    logic              take, put, pperr, rx_line;
    logic [DATA_W-1:0] hold_word, pword;

    assign fmt = '{prescale: cfg_prescale, charlen: cfg_charlen, cpol: cfg_cpol,
                   phase: cfg_phase, lsb_first: cfg_lsb_first, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, gap: cfg_gap};

    // Receiver source: the pin, or the outgoing line in loopback.
    assign rx_line = cfg_loopback ? mosi : miso;

    spi_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
        .take(take), .full(tx_full), .word(hold_word));

    spi_serdes #(.DATA_W(DATA_W)) u_sd (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .word_avail(tx_full),
        .word_in(hold_word), .rx_line(rx_line), .take(take), .sclk(sclk),
        .mosi(mosi), .busy(busy), .put(put), .rx_word(pword), .rx_perr(pperr));

    spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .put(put), .pdata(pword), .pperr(pperr),
        .rd(rx_rd), .data(rx_data), .empty(rx_empty), .ovr(rx_overrun),
        .perr(rx_par_err));

    AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_cpol)); // R4
    AST_IDLE_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi); // R12
    AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !cfg_par_en) |=> !rx_par_err); // R6
endmodule

// File: tb/tb_spi_word_engine.sv
module tb_spi_word_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_prescale = 8'd2;
    logic [4:0]  cfg_charlen = 5'd8;
    logic        cfg_cpol = 1'b0, cfg_phase = 1'b1, cfg_lsb_first = 1'b0;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_loopback = 1'b1;
    logic [5:0]  cfg_gap = 6'd0;
    logic [15:0] tx_data = '0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
    logic        tx_full, rx_empty, rx_overrun, rx_par_err, sclk, mosi, busy;
    logic [15:0] rx_data;

    always #4 clk = ~clk;

    spi_word_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_charlen(cfg_charlen),
        .cfg_cpol(cfg_cpol), .cfg_phase(cfg_phase), .cfg_lsb_first(cfg_lsb_first),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_gap(cfg_gap),
        .cfg_loopback(cfg_loopback), .tx_data(tx_data), .tx_wr(tx_wr), .tx_full(tx_full),
        .rx_data(rx_data), .rx_rd(rx_rd), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .rx_par_err(rx_par_err), .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy));

    int checks = 0, fails = 0;
    logic [63:0] mon_bits, sl_bits, exp_bits;
    int mon_n, lead_cnt, busy_cnt, sl_i, idle_bad;
    bit mon_en = 1'b0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Line bit k of a word as the requirements define it (R3, R6).
    function automatic bit line_bit(input logic [15:0] w, input int k, input int L,
                                    input bit lsb, input bit odd);
        bit p;
        if (k < L) return lsb ? w[k] : w[L-1-k];
        p = odd;
        for (int i = 0; i < L; i++) p ^= w[i];
        return p;
    endfunction

    // Monitor and slave: edges seen between falling clock edges.
    always @(negedge clk) begin
        if (mon_en) begin
            if (busy) busy_cnt++;
            if (!busy && (sclk !== cfg_cpol || mosi !== 1'b0)) idle_bad++;
            if (sclk !== prev_sclk) begin
                automatic bit lead_e = (prev_sclk === cfg_cpol);
                if (lead_e) lead_cnt++;
                if (cfg_phase == lead_e && mon_n < 64) begin
                    mon_bits[mon_n] = prev_mosi;
                    mon_n++;
                end
                if (cfg_phase && !lead_e) begin
                    sl_i++;
                    if (sl_i < 64) miso = sl_bits[sl_i];
                end
                if (!cfg_phase && lead_e) begin
                    if (sl_i < 64) miso = sl_bits[sl_i];
                    sl_i++;
                end
            end
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic set_cfg(input int pre, input int L, input bit cpol, input bit ph,
                           input bit lsb, input bit pe, input bit odd, input int gap,
                           input bit lp);
        @(negedge clk);
        cfg_prescale = 8'(pre); cfg_charlen = 5'(L); cfg_cpol = cpol; cfg_phase = ph;
        cfg_lsb_first = lsb; cfg_par_en = pe; cfg_par_odd = odd; cfg_gap = 6'(gap);
        cfg_loopback = lp;
        @(negedge clk);
        @(negedge clk);
    endtask

    // mode 0: one word, 1: two back-to-back words, 2: second write while full.
    task automatic run_words(input logic [15:0] w0, input logic [15:0] w1, input int mode);
        int L, N, D, nw, gap, off, errs;
        logic [15:0] er, msk;
        bit pb, eperr;
        L = int'(cfg_charlen); N = L + int'(cfg_par_en); D = int'(cfg_prescale) + 1;
        gap = int'(cfg_gap); nw = (mode == 1) ? 2 : 1;
        exp_bits = '0;
        for (int k = 0; k < N; k++) begin
            exp_bits[k] = line_bit(w0, k, L, cfg_lsb_first, cfg_par_odd);
            if (nw == 2) exp_bits[N+k] = line_bit(w1, k, L, cfg_lsb_first, cfg_par_odd);
        end
        if (cfg_loopback) sl_bits = ~exp_bits;
        mon_n = 0; lead_cnt = 0; busy_cnt = 0; sl_i = 0; idle_bad = 0;
        miso = sl_bits[0];
        mon_en = 1'b1;
        tx_data = w0; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        if (mode == 2) begin
            chk(tx_full == 1'b1, "R8", "tx_full after write", tx_full, 1);
            tx_data = w1; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
        end
        if (mode == 1) begin
            while (tx_full) @(negedge clk);
            tx_data = w1; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
        end
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        mon_en = 1'b0;
        off = (nw - 1) * N; er = '0;
        for (int k = 0; k < L; k++) begin
            pb = cfg_loopback ? exp_bits[off+k] : sl_bits[off+k];
            if (cfg_lsb_first) er[k] = pb; else er[L-1-k] = pb;
        end
        pb = cfg_loopback ? exp_bits[off+L] : sl_bits[off+L];
        eperr = cfg_par_en && (pb != ((^er) ^ cfg_par_odd));
        errs = 0;
        for (int k = 0; k < nw * N; k++) if (mon_bits[k] !== exp_bits[k]) errs++;
        chk(lead_cnt == nw * N, "R2", "leading edges", lead_cnt, nw * N);
        chk(busy_cnt == nw * (N + gap) * D, "R7", "busy cycles (R1 timing)", busy_cnt, nw * (N + gap) * D);
        chk(mon_n == nw * N && errs == 0, "R5", "mosi line bits at sample edges (R3 R6)", errs, 0);
        chk(rx_data === er, cfg_loopback ? "R11" : "R3", "rx_data", rx_data, er);
        msk = 16'hFFFF >> (16 - L);
        chk((rx_data & ~msk) == 16'h0, "R9", "zero fill above length", rx_data, er);
        chk(rx_empty == 1'b0, "R9", "rx_empty after word", rx_empty, 0);
        chk(rx_par_err == eperr, "R6", "parity error flag", rx_par_err, eperr);
        chk(rx_overrun == (mode == 1), "R10", "overrun flag", rx_overrun, mode == 1);
        chk(idle_bad == 0, "R4", "idle sclk/mosi level (R12)", idle_bad, 0);
        chk(tx_full == 1'b0, "R8", "tx_full after run", tx_full, 0);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_empty == 1'b1 && rx_overrun == 1'b0, "R10", "read clears empty/overrun (R9)",
            {rx_empty, rx_overrun}, 2'b10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd20517));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(busy == 0 && tx_full == 0 && rx_empty == 1 && rx_overrun == 0 &&
            rx_par_err == 0 && mosi == 0 && sclk == 0, "R12", "reset state",
            {busy, tx_full, rx_empty, rx_overrun, rx_par_err, mosi, sclk}, 7'b0010000);

        // R1 R2: shortest divisor, msb first, loopback
        set_cfg(2, 8, 0, 1, 0, 0, 0, 0, 1);
        run_words(16'h00A5, 16'h0, 0);
        // R1 R2 R6: longest divisor, 16 bits, lsb first, odd parity, late phase, pin input
        set_cfg(255, 16, 1, 0, 1, 1, 1, 0, 0);
        sl_bits = {$urandom, $urandom};
        run_words(16'hC3E1, 16'h0, 0);
        // R7 R8 R10: 2-bit words with maximal gap, back to back
        set_cfg(2, 2, 1, 1, 1, 1, 0, 63, 1);
        run_words(16'h0002, 16'h0001, 1);
        // R8: write while full is ignored
        set_cfg(3, 5, 0, 0, 0, 0, 0, 1, 1);
        run_words(16'h0013, 16'h000C, 2);
        // R6: parity bit forced wrong on the pin, then right
        set_cfg(4, 7, 0, 1, 0, 1, 0, 0, 0);
        w = 16'h005B;
        sl_bits = '0;
        for (int k = 0; k < 8; k++) sl_bits[k] = line_bit(w, k, 7, 0, 0);
        sl_bits[7] = ~sl_bits[7];
        run_words(16'h0000, 16'h0, 0);
        sl_bits[7] = ~sl_bits[7];
        run_words(16'h0000, 16'h0, 0);

        // Random formats and words
        for (int it = 0; it < 40; it++) begin
            set_cfg($urandom_range(9, 2), $urandom_range(16, 2), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3, 0),
                    1'($urandom));
            sl_bits = {$urandom, $urandom};
            run_words(16'($urandom), 16'($urandom), $urandom_range(2, 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule